// File: doc/BRIEF.md
# Half-Width Karatsuba Multiply-Accumulate Unit

This unit sits beside a 32-bit integer pipeline and computes products and accumulations into a 96-bit result register made of an overflow word, a high word and a low word. Once an operation is started, the pipeline may keep issuing independent instructions while the unit works. The pipeline reads the result words back through three read ports. A read that arrives while the unit is busy must be stalled by the pipeline until the busy flag drops.

The 32x32 product is built from three half-word products. These are taken one per cycle through a single 17x17 signed multiplier, using the Karatsuba split: the cross term comes from the signed product of two 17-bit differences. In binary-field mode, a 16x16 carry-less multiplier takes the place of the signed one. In the same mode, the difference units and the summing adders switch to XOR. This gives carry-less multiply and multiply-XOR into the same 96-bit register. Prime-field product-scanning support adds four operations: multiply-accumulate, doubled multiply-accumulate, add of a two-word value, and a 32-bit right shift of the register.

Top module: `kmac_unit`

## Requirements
- R1: After reset, busy_o is 0 and ovf_o, hi_o and lo_o are all zero.
- R2: A start accepted while idle raises busy_o for exactly four cycles. The new {ovf_o,hi_o,lo_o} is visible in the cycle busy_o falls, which is four clock edges after the edge that sampled start_i. Every operation takes this latency.
- R3: A start_i pulse while busy_o is high is ignored. The running operation finishes on its original schedule, with its original operands and result.
- R4: While busy_o is high, ovf_o, hi_o and lo_o keep the values they had before the operation started.
- R5: op_i=0 (signed multiply) writes the two's-complement 64-bit product of rs_i and rt_i, sign-extended to 96 bits, with the low word in lo_o, the high word in hi_o and the sign fill in ovf_o.
- R6: op_i=1 (unsigned multiply) writes the 64-bit unsigned product, with ovf_o set to zero.
- R7: op_i=2 adds the unsigned product rs_i·rt_i to the 96-bit register {ovf_o,hi_o,lo_o}, modulo 2^96. Carries out of hi_o reach ovf_o.
- R8: op_i=3 adds twice the unsigned product rs_i·rt_i to the 96-bit register, modulo 2^96.
- R9: op_i=4 adds the 64-bit value {rs_i,rt_i} (rs_i as the upper word) to the 96-bit register, modulo 2^96.
- R10: op_i=5 shifts the 96-bit register right by 32 bits with zero fill. Afterwards lo_o holds the old hi_o, hi_o holds the old ovf_o, and ovf_o is zero.
- R11: op_i=6 writes the 63-bit carry-less (GF(2) polynomial) product of rs_i and rt_i, zero-extended to 96 bits.
- R12: op_i=7 XORs the carry-less product of rs_i and rt_i into the 96-bit register.
- R13: Extreme operands produce exact results, for example 0x80000000 squared signed, 0xFFFFFFFF squared unsigned, and 0xFFFFFFFF squared carry-less.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| op_i | input | 3 | Operation code (0 to 7, see requirements) |
| rs_i | input | 32 | First operand |
| rt_i | input | 32 | Second operand |
| busy_o | output | 1 | High while an operation is in progress |
| hi_o | output | 32 | Bits 63:32 of the result register |
| lo_o | output | 32 | Bits 31:0 of the result register |
| ovf_o | output | 32 | Bits 95:64 of the result register |

## Verification
Some properties are checked on every cycle. The first is the step sequence, so busy lasts exactly four cycles and a start during busy never restarts the count. The result register must also stay frozen until the final step. A shift must leave ovf_o zero with the old high word moved down. Every unsigned multiply and carry-less multiply must leave the top bits clear, and every signed multiply must fill ovf_o with copies of the high word's sign bit. The exact arithmetic of each operation can only be shown by the bench's scenarios, which compare it against a software model. The same holds for the signed Karatsuba cross term and its carries, for accumulation chains that carry into the overflow word, and for extreme operands.

// File: rtl/kmac_pkg.sv
package kmac_pkg;
  typedef enum logic [2:0] {
    OP_MUL_S  = 3'd0,
    OP_MUL_U  = 3'd1,
    OP_MAC    = 3'd2,
    OP_MAC2   = 3'd3,
    OP_ADDW   = 3'd4,
    OP_SHR    = 3'd5,
    OP_CLMUL  = 3'd6,
    OP_CLMAC  = 3'd7
  } kmac_op_e;

  localparam int unsigned KMAC_STEPS = 4;

  function automatic logic is_carryless(kmac_op_e op);
    return (op == OP_CLMUL) || (op == OP_CLMAC);
  endfunction
endpackage

// File: rtl/kmac_dual_add.sv
module kmac_dual_add #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 2
) (
  input  logic                xor_mode_i,
  input  logic [N-1:0][W-1:0] terms_i,
  output logic [W-1:0]        sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) begin
      if (xor_mode_i) sum_o = sum_o ^ terms_i[i];
      else            sum_o = sum_o + terms_i[i];
    end
  end
endmodule

// File: rtl/kmac_halfmul.sv
module kmac_halfmul #(
  parameter int unsigned HALF = 16,
  localparam int unsigned PW  = 2 * HALF + 2,
  localparam int unsigned CW  = 2 * HALF - 1
) (
  input  logic            cl_mode_i,
  input  logic [HALF:0]   op_a_i,
  input  logic [HALF:0]   op_b_i,
  output logic [PW-1:0]   prod_o
);
  logic signed [PW-1:0] sprod;
  logic [CW-1:0]        cprod;

  // signed 17x17 path
  always_comb begin
    sprod = $signed(op_a_i) * $signed(op_b_i);
  end

  // carry-less 16x16 path on the low HALF bits
  always_comb begin
    cprod = '0;
    for (int i = 0; i < HALF; i++) begin
      if (op_b_i[i]) cprod = cprod ^ ({{(HALF-1){1'b0}}, op_a_i[HALF-1:0]} << i);
    end
  end

  assign prod_o = cl_mode_i ? {{(PW-CW){1'b0}}, cprod} : sprod;
endmodule

// File: rtl/kmac_ctrl.sv
module kmac_ctrl #(
  parameter int unsigned STEPS = 4,
  localparam int unsigned SW   = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic [SW-1:0] step_o,
  output logic          load_o,
  output logic          final_o
);
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  logic          busy_q, busy_d;
  logic [SW-1:0] step_q, step_d;

  assign load_o  = start_i && !busy_q;
  assign final_o = busy_q && (step_q == LAST);

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    if (load_o) begin
      busy_d = 1'b1;
      step_d = '0;
    end else if (final_o) begin
      busy_d = 1'b0;
      step_d = '0;
    end else if (busy_q) begin
      step_d = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
    end
  end

  assign busy_o = busy_q;
  assign step_o = step_q;

  a_r2_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && step_q != LAST) |=> (busy_q && step_q == $past(step_q) + 1'b1));
  a_r2_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && step_q == LAST) |=> !busy_q);
  a_r2_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && step_q == '0));
  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_q) |=> !(busy_q && step_q == '0));
endmodule

// File: rtl/kmac_unit.sv
module kmac_unit
  import kmac_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned HALF  = XLEN / 2,
  localparam int unsigned ACC_W = 3 * XLEN,
  localparam int unsigned PW    = 2 * HALF + 2,
  localparam int unsigned SW    = $clog2(KMAC_STEPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic            busy_o,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o,
  output logic [XLEN-1:0] ovf_o
);
  logic          busy, load, fin;
  logic [SW-1:0] step;

  kmac_ctrl #(.STEPS(KMAC_STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy), .step_o(step), .load_o(load), .final_o(fin)
  );

  // operand and partial-product registers
  kmac_op_e        op_q;
  logic            neg_q;
  logic [XLEN-1:0] a_q, b_q, ll_q, hh_q;
  logic [PW-1:0]   mid_q;
  logic [ACC_W-1:0] acc_q, acc_d;

  kmac_op_e op_in;
  assign op_in = kmac_op_e'(op_i);

  logic cl_mode;
  assign cl_mode = is_carryless(op_q);

  logic [HALF-1:0] a_hi, a_lo, b_hi, b_lo;
  assign a_hi = a_q[XLEN-1:HALF];
  assign a_lo = a_q[HALF-1:0];
  assign b_hi = b_q[XLEN-1:HALF];
  assign b_lo = b_q[HALF-1:0];

  // dual-mode difference units: AH-AL and BL-BH
  logic [1:0][HALF:0] da_terms, db_terms;
  logic [HALF:0]      diff_a, diff_b;

  assign da_terms[0] = {1'b0, a_hi};
  assign da_terms[1] = cl_mode ? {1'b0, a_lo} : ((HALF+1)'(0) - {1'b0, a_lo});
  assign db_terms[0] = {1'b0, b_lo};
  assign db_terms[1] = cl_mode ? {1'b0, b_hi} : ((HALF+1)'(0) - {1'b0, b_hi});

  kmac_dual_add #(.W(HALF+1), .N(2)) u_sub_a (
    .xor_mode_i(cl_mode), .terms_i(da_terms), .sum_o(diff_a)
  );
  kmac_dual_add #(.W(HALF+1), .N(2)) u_sub_b (
    .xor_mode_i(cl_mode), .terms_i(db_terms), .sum_o(diff_b)
  );

  // shared half-width multiplier, operands picked by step
  logic [HALF:0] mul_a, mul_b;
  logic [PW-1:0] mul_p;

  always_comb begin
    unique case (step)
      SW'(0):  begin mul_a = {1'b0, a_lo}; mul_b = {1'b0, b_lo}; end
      SW'(1):  begin mul_a = {1'b0, a_hi}; mul_b = {1'b0, b_hi}; end
      default: begin mul_a = diff_a;       mul_b = diff_b;       end
    endcase
  end

  kmac_halfmul #(.HALF(HALF)) u_mul (
    .cl_mode_i(cl_mode), .op_a_i(mul_a), .op_b_i(mul_b), .prod_o(mul_p)
  );

  // four-input product assembly adder
  logic [3:0][ACC_W-1:0] asm_terms;
  logic [ACC_W-1:0]      mag;

  assign asm_terms[0] = {{(ACC_W-2*XLEN){1'b0}}, hh_q, ll_q};
  assign asm_terms[1] = {{(ACC_W-PW-HALF){mid_q[PW-1]}}, mid_q, {HALF{1'b0}}};
  assign asm_terms[2] = {{(ACC_W-XLEN-HALF){1'b0}}, hh_q, {HALF{1'b0}}};
  assign asm_terms[3] = {{(ACC_W-XLEN-HALF){1'b0}}, ll_q, {HALF{1'b0}}};

  kmac_dual_add #(.W(ACC_W), .N(4)) u_asm (
    .xor_mode_i(cl_mode), .terms_i(asm_terms), .sum_o(mag)
  );

  // accumulation stage
  logic [ACC_W-1:0]      prod_s;
  logic [1:0][ACC_W-1:0] acc_terms;
  logic [ACC_W-1:0]      acc_sum;

  assign prod_s = neg_q ? (ACC_W'(0) - mag) : mag;

  always_comb begin
    acc_terms[0] = acc_q;
    acc_terms[1] = prod_s;
    unique case (op_q)
      OP_MUL_S, OP_MUL_U, OP_CLMUL: acc_terms[0] = '0;
      OP_MAC2:  acc_terms[1] = prod_s << 1;
      OP_ADDW:  acc_terms[1] = {{(ACC_W-2*XLEN){1'b0}}, a_q, b_q};
      default:  acc_terms[1] = prod_s;
    endcase
  end

  kmac_dual_add #(.W(ACC_W), .N(2)) u_acc (
    .xor_mode_i(cl_mode), .terms_i(acc_terms), .sum_o(acc_sum)
  );

  always_comb begin
    acc_d = acc_q;
    if (fin) begin
      if (op_q == OP_SHR) acc_d = acc_q >> XLEN;
      else                acc_d = acc_sum;
    end
  end

  // operand capture on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_MUL_S;
      neg_q <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (load) begin
      op_q  <= op_in;
      neg_q <= (op_in == OP_MUL_S) && (rs_i[XLEN-1] ^ rt_i[XLEN-1]);
      a_q   <= ((op_in == OP_MUL_S) && rs_i[XLEN-1]) ? (XLEN'(0) - rs_i) : rs_i;
      b_q   <= ((op_in == OP_MUL_S) && rt_i[XLEN-1]) ? (XLEN'(0) - rt_i) : rt_i;
    end
  end

  // partial products, one per step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ll_q  <= '0;
      hh_q  <= '0;
      mid_q <= '0;
    end else if (busy) begin
      if (step == SW'(0)) ll_q  <= mul_p[XLEN-1:0];
      if (step == SW'(1)) hh_q  <= mul_p[XLEN-1:0];
      if (step == SW'(2)) mid_q <= mul_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign busy_o = busy;
  assign lo_o   = acc_q[XLEN-1:0];
  assign hi_o   = acc_q[2*XLEN-1:XLEN];
  assign ovf_o  = acc_q[ACC_W-1:2*XLEN];

  a_r4_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fin) |=> $stable({ovf_o, hi_o, lo_o}));
  a_r10_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_q == OP_SHR) |=> (ovf_o == '0 && lo_o == $past(hi_o) && hi_o == $past(ovf_o)));
  a_r6_unsigned_top: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_q == OP_MUL_U) |=> (ovf_o == '0));
  a_r5_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_q == OP_MUL_S) |=> (ovf_o == {XLEN{hi_o[XLEN-1]}}));
  a_r11_clmul_width: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && op_q == OP_CLMUL) |=> (ovf_o == '0 && !hi_o[XLEN-1]));
endmodule

// File: tb/kmac_unit_bench.sv
`timescale 1ns/1ps
module kmac_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  op_i;
  logic [31:0] rs_i, rt_i;
  logic        busy_o;
  logic [31:0] hi_o, lo_o, ovf_o;

  int checks;
  int errors;
  bit done;
  logic [95:0] model;

  kmac_unit u_kmac_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .rs_i(rs_i), .rt_i(rt_i), .busy_o(busy_o),
    .hi_o(hi_o), .lo_o(lo_o), .ovf_o(ovf_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [62:0] clmul32(logic [31:0] a, logic [31:0] b);
    logic [62:0] r = '0;
    for (int i = 0; i < 32; i++) if (b[i]) r = r ^ ({31'b0, a} << i);
    return r;
  endfunction

  function automatic logic [95:0] expect_of(logic [2:0] op, logic [31:0] a,
                                            logic [31:0] b, logic [95:0] acc);
    logic [95:0] sa = {{64{a[31]}}, a};
    logic [95:0] sb = {{64{b[31]}}, b};
    logic [95:0] ua = {64'b0, a};
    logic [95:0] ub = {64'b0, b};
    case (op)
      3'd0: return sa * sb;
      3'd1: return ua * ub;
      3'd2: return acc + ua * ub;
      3'd3: return acc + ((ua * ub) << 1);
      3'd4: return acc + {32'b0, a, b};
      3'd5: return acc >> 32;
      3'd6: return {33'b0, clmul32(a, b)};
      default: return acc ^ {33'b0, clmul32(a, b)};
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one operation; optionally pulse start again while busy
  task automatic run_op(logic [2:0] op, logic [31:0] a, logic [31:0] b, bit inject,
                        string req);
    logic [95:0] prev = {ovf_o, hi_o, lo_o};
    logic [95:0] exp  = expect_of(op, a, b, prev);
    start_i = 1'b1; op_i = op; rs_i = a; rt_i = b;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R2 busy after start", {95'b0, busy_o}, 96'd1);
    if (inject) begin
      start_i = 1'b1; op_i = 3'(op + 3'd1); rs_i = ~a; rt_i = b ^ 32'h5a5a_a5a5;
    end
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(busy_o === 1'b1, "R2 busy in fourth cycle", {95'b0, busy_o}, 96'd1);
    check({ovf_o, hi_o, lo_o} === prev, "R4 result held while busy", {ovf_o, hi_o, lo_o}, prev);
    @(negedge clk);
    check(busy_o === 1'b0, "R2 busy dropped", {95'b0, busy_o}, 96'd0);
    check({ovf_o, hi_o, lo_o} === exp, inject ? "R3 start ignored while busy" : req,
          {ovf_o, hi_o, lo_o}, exp);
    model = exp;
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    start_i = 0; op_i = 0; rs_i = 0; rt_i = 0;
    rst_n = 0;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && {ovf_o, hi_o, lo_o} === 96'b0, "R1 reset state",
          {busy_o, ovf_o[30:0], hi_o, lo_o}, 96'b0);
    rst_n = 1;
    @(negedge clk);

    run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 0, "R13 R5 signed min squared");
    run_op(3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 0, "R5 signed -1*1");
    run_op(3'd0, 32'h1234_5678, 32'hF00D_BEEF, 0, "R5 signed mixed");
    run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R13 R6 unsigned max squared");
    run_op(3'd1, 32'h0001_0000, 32'h0000_FFFF, 0, "R6 unsigned half boundary");
    run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R7 accumulate into overflow");
    run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R7 accumulate chain");
    run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R8 doubled accumulate");
    run_op(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R9 two-word add");
    run_op(3'd5, 32'h0, 32'h0, 0, "R10 shift right one word");
    run_op(3'd5, 32'h0, 32'h0, 0, "R10 shift right again");
    run_op(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R13 R11 carry-less max");
    run_op(3'd6, 32'h8000_0001, 32'h0000_0003, 0, "R11 carry-less sparse");
    run_op(3'd7, 32'hDEAD_BEEF, 32'h1357_9BDF, 0, "R12 carry-less accumulate");
    run_op(3'd0, 32'h7FFF_FFFF, 32'h8000_0000, 1, "R3");

    for (int n = 0; n < 80; n++) begin
      logic [2:0]  op = 3'($urandom_range(0, 7));
      logic [31:0] a  = $urandom;
      logic [31:0] b  = $urandom;
      string req;
      case (op)
        3'd0: req = "R5 random signed";
        3'd1: req = "R6 random unsigned";
        3'd2: req = "R7 random accumulate";
        3'd3: req = "R8 random doubled accumulate";
        3'd4: req = "R9 random two-word add";
        3'd5: req = "R10 random shift";
        3'd6: req = "R11 random carry-less";
        default: req = "R12 random carry-less accumulate";
      endcase
      run_op(op, a, b, (n % 7) == 3, req);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule